// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Block

This block is the software-visible face of a multi-channel DMA controller. A simple 32-bit register bus (separate read and write strobes, a 12-bit byte address, write data and registered read data) reaches a global area, one five-word window per channel, and a read-only identification area near the top of the 4 KiB space. The block holds each channel's source address, destination address, next-item pointer, control word and configuration word. It also holds the global configuration and sync registers, and the raw terminal-count and error interrupt bits. The channel count `NCH` is 2 or 8.

The channel engines live outside this block. They report completion and faults as single-cycle pulses on `tc_set` and `err_set`, and they read the global and per-channel enables from `dma_on` and `chan_on`. Each channel's configuration word holds two bits that gate its interrupts into the masked views. A single interrupt line is high while any unmasked raw bit is set. Each access is classified by an address-region decode whose named outcomes are `RG_GLOBAL`, `RG_CHAN`, `RG_BADCH`, `RG_IDENT` and `RG_NONE`. The read multiplexer selects a source from that classification. The block has no sequential control state: every access completes in one cycle.

Top module: `dmar_top`

## Requirements
- R1: After reset every register reads as zero, and `irq`, `dma_on` and `chan_on` are low.
- R2: Addresses 0x100–0x1FF form channel windows. The channel index is address bits [7:5] and the word within the window is bits [4:2]. Word 0 is source, 1 destination, 2 next-item pointer, 3 control and 4 configuration, all fully 32-bit read/write. Words 5–7 of a window read zero and ignore writes.
- R3: An access to a channel index at or above `NCH` reads zero and changes no state.
- R4: A pulse on `tc_set[n]` or `err_set[n]` sets raw bit n. Writing global word 2 (byte 0x008) clears every raw terminal-count bit whose data bit is 1, and word 4 (0x010) does the same for raw error bits. A set pulse in the same cycle as a clear of that bit leaves the bit set.
- R5: Terminal-count mask bit n equals bit 15 of channel n's configuration, and error mask bit n equals bit 14. Word 1 (0x004) reads masked terminal-count bits, word 3 (0x00C) masked error bits, and word 0 (0x000) their OR. Word 5 (0x014) reads raw terminal-count bits and word 6 (0x018) raw error bits.
- R6: `irq` is high exactly while some masked terminal-count or masked error bit is set.
- R7: Word 7 (0x01C) and `chan_on` give a bitmap whose bit n is channel n's configuration bit 0.
- R8: Reads of 0xFE0–0xFFC return one identification byte per word, in the order 0x80,0x10,0x04,0x0A,0x0D,0xF0,0x05,0xB1. With `NCH`=2 the first byte is 0x81.
- R9: Word 12 (0x030) stores global configuration bits [2:0], and bit 0 drives `dma_on`. Word 13 (0x034) stores the low `SYNC_W` (default 16) bits of sync.
- R10: Words 8–11 (0x020–0x02C) and all unmapped addresses read zero and ignore writes.
- R11: Read data appears in `bus_rdata` on the cycle after the `bus_rd` edge. `bus_rdata` is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tc_set | input | NCH | Terminal-count pulses from the channel engines |
| err_set | input | NCH | Error pulses from the channel engines |
| irq | output | 1 | Combined masked interrupt |
| dma_on | output | 1 | Controller enable |
| chan_on | output | NCH | Per-channel enable bits |

## Verification
Register traffic is exercised with several patterns, and each one exposes a different kind of fault:
- Distinct values written to different channels and words expose address-decode aliasing.
- All-ones writes to reserved window words, request words and the sync register expose writes that land where they should not.
- Reads of every identification position expose a wrong byte order.

The interrupt path is driven with pulses on channels whose mask bits differ, so that the raw, masked and combined views must disagree in a known way. A clear is then issued in the same cycle as a set pulse to test the priority of set over clear. A second instance with two channels shows that out-of-range windows are inert and that the first identification byte changes with the channel count.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_GLOBAL,
        RG_CHAN,
        RG_BADCH,
        RG_IDENT
    } region_e;

    // global word numbers (byte address bits [7:2])
    localparam logic [5:0] GW_STAT     = 6'd0;
    localparam logic [5:0] GW_TC_STAT  = 6'd1;
    localparam logic [5:0] GW_TC_CLR   = 6'd2;
    localparam logic [5:0] GW_ERR_STAT = 6'd3;
    localparam logic [5:0] GW_ERR_CLR  = 6'd4;
    localparam logic [5:0] GW_TC_RAW   = 6'd5;
    localparam logic [5:0] GW_ERR_RAW  = 6'd6;
    localparam logic [5:0] GW_ENABLED  = 6'd7;
    localparam logic [5:0] GW_CONFIG   = 6'd12;
    localparam logic [5:0] GW_SYNC     = 6'd13;

    // words inside a channel window
    localparam logic [2:0] CW_SRC  = 3'd0;
    localparam logic [2:0] CW_DST  = 3'd1;
    localparam logic [2:0] CW_NEXT = 3'd2;
    localparam logic [2:0] CW_CTL  = 3'd3;
    localparam logic [2:0] CW_CFG  = 3'd4;

    // channel configuration bit positions decoded by this block
    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_ERRM_BIT  = 14;
    localparam int CFG_TCM_BIT   = 15;

    localparam int GCFG_W = 3;

endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
    import dmar_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [2:0]        chan_idx,
    output logic [2:0]        chan_word,
    output logic [5:0]        glob_word,
    output logic [2:0]        id_idx
);
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(12'hFE0);

    assign chan_idx  = addr[7:5];
    assign chan_word = addr[4:2];
    assign glob_word = addr[7:2];
    assign id_idx    = addr[4:2];

    always_comb begin
        if (addr[ADDR_W-1:8] == 4'h1) begin
            region = (32'(chan_idx) < NCH) ? RG_CHAN : RG_BADCH;
        end else if (addr >= ID_BASE) begin
            region = RG_IDENT;
        end else if (addr[ADDR_W-1:8] == 4'h0) begin
            region = RG_GLOBAL;
        end else begin
            region = RG_NONE;
        end
    end
endmodule

// File: rtl/dmar_chan_bank.sv
module dmar_chan_bank
    import dmar_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        chan_idx,
    input  logic [2:0]        chan_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic [NCH-1:0]    cfg_en,
    output logic [NCH-1:0]    cfg_tcm,
    output logic [NCH-1:0]    cfg_errm
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [DATA_W-1:0] src_q  [NCH];
    logic [DATA_W-1:0] dst_q  [NCH];
    logic [DATA_W-1:0] next_q [NCH];
    logic [DATA_W-1:0] ctl_q  [NCH];
    logic [DATA_W-1:0] cfg_q  [NCH];

    logic [IDX_W-1:0] sel;
    assign sel = chan_idx[IDX_W-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        assign hit = wr_en && (32'(chan_idx) == c);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[c]  <= '0;
                dst_q[c]  <= '0;
                next_q[c] <= '0;
                ctl_q[c]  <= '0;
                cfg_q[c]  <= '0;
            end else if (hit) begin
                unique case (chan_word)
                    CW_SRC:  src_q[c]  <= wdata;
                    CW_DST:  dst_q[c]  <= wdata;
                    CW_NEXT: next_q[c] <= wdata;
                    CW_CTL:  ctl_q[c]  <= wdata;
                    CW_CFG:  cfg_q[c]  <= wdata;
                    default: ;
                endcase
            end
        end

        assign cfg_en[c]   = cfg_q[c][CFG_EN_BIT];
        assign cfg_tcm[c]  = cfg_q[c][CFG_TCM_BIT];
        assign cfg_errm[c] = cfg_q[c][CFG_ERRM_BIT];
    end

    always_comb begin
        unique case (chan_word)
            CW_SRC:  rd_val = src_q[sel];
            CW_DST:  rd_val = dst_q[sel];
            CW_NEXT: rd_val = next_q[sel];
            CW_CTL:  rd_val = ctl_q[sel];
            CW_CFG:  rd_val = cfg_q[sel];
            default: rd_val = '0;
        endcase
    end
endmodule

// File: rtl/dmar_irq.sv
module dmar_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    input  logic           tc_clr_we,
    input  logic           err_clr_we,
    input  logic [NCH-1:0] clr_bits,
    input  logic [NCH-1:0] tc_mask,
    input  logic [NCH-1:0] err_mask,
    output logic [NCH-1:0] tc_raw,
    output logic [NCH-1:0] err_raw,
    output logic [NCH-1:0] tc_masked,
    output logic [NCH-1:0] err_masked,
    output logic           irq
);
    logic [NCH-1:0] tc_keep, err_keep;

    assign tc_keep  = tc_clr_we  ? (tc_raw  & ~clr_bits) : tc_raw;
    assign err_keep = err_clr_we ? (err_raw & ~clr_bits) : err_raw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_raw  <= '0;
            err_raw <= '0;
        end else begin
            tc_raw  <= tc_keep  | tc_set;
            err_raw <= err_keep | err_set;
        end
    end

    assign tc_masked  = tc_raw  & tc_mask;
    assign err_masked = err_raw & err_mask;
    assign irq        = (|tc_masked) | (|err_masked);

    // set pulses always land, even against a clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set != '0) |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

    assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((err_raw & $past(err_set)) == $past(err_set)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr_we && tc_set == '0) |=> ((tc_raw & $past(clr_bits)) == '0));

    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_raw == '0 && err_raw == '0) |-> !irq);
endmodule

// File: rtl/dmar_top.sv
module dmar_top
    import dmar_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int SYNC_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [11:0]    bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    output logic           irq,
    output logic           dma_on,
    output logic [NCH-1:0] chan_on
);
    region_e    region;
    logic [2:0] chan_idx, chan_word, id_idx;
    logic [5:0] glob_word;

    dmar_decode #(.NCH(NCH), .ADDR_W(12)) u_decode (
        .addr      (bus_addr),
        .region    (region),
        .chan_idx  (chan_idx),
        .chan_word (chan_word),
        .glob_word (glob_word),
        .id_idx    (id_idx)
    );

    logic [31:0]    chan_rd;
    logic [NCH-1:0] cfg_tcm, cfg_errm;

    dmar_chan_bank #(.NCH(NCH), .DATA_W(32)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && region == RG_CHAN),
        .chan_idx  (chan_idx),
        .chan_word (chan_word),
        .wdata     (bus_wdata),
        .rd_val    (chan_rd),
        .cfg_en    (chan_on),
        .cfg_tcm   (cfg_tcm),
        .cfg_errm  (cfg_errm)
    );

    logic           glob_wr;
    logic [NCH-1:0] tc_raw, err_raw, tc_msk, err_msk;

    assign glob_wr = bus_wr && region == RG_GLOBAL;

    dmar_irq #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr_we  (glob_wr && glob_word == GW_TC_CLR),
        .err_clr_we (glob_wr && glob_word == GW_ERR_CLR),
        .clr_bits   (bus_wdata[NCH-1:0]),
        .tc_mask    (cfg_tcm),
        .err_mask   (cfg_errm),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .tc_masked  (tc_msk),
        .err_masked (err_msk),
        .irq        (irq)
    );

    logic [GCFG_W-1:0] gcfg_q;
    logic [SYNC_W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q <= '0;
            sync_q <= '0;
        end else if (glob_wr) begin
            if (glob_word == GW_CONFIG) gcfg_q <= bus_wdata[GCFG_W-1:0];
            if (glob_word == GW_SYNC)   sync_q <= bus_wdata[SYNC_W-1:0];
        end
    end

    assign dma_on = gcfg_q[0];

    function automatic logic [7:0] ident_byte(input logic [2:0] i);
        unique case (i)
            3'd0:    ident_byte = (NCH == 2) ? 8'h81 : 8'h80;
            3'd1:    ident_byte = 8'h10;
            3'd2:    ident_byte = 8'h04;
            3'd3:    ident_byte = 8'h0A;
            3'd4:    ident_byte = 8'h0D;
            3'd5:    ident_byte = 8'hF0;
            3'd6:    ident_byte = 8'h05;
            default: ident_byte = 8'hB1;
        endcase
    endfunction

    logic [31:0] glob_rd, rd_next;

    always_comb begin
        unique case (glob_word)
            GW_STAT:     glob_rd = 32'(tc_msk | err_msk);
            GW_TC_STAT:  glob_rd = 32'(tc_msk);
            GW_ERR_STAT: glob_rd = 32'(err_msk);
            GW_TC_RAW:   glob_rd = 32'(tc_raw);
            GW_ERR_RAW:  glob_rd = 32'(err_raw);
            GW_ENABLED:  glob_rd = 32'(chan_on);
            GW_CONFIG:   glob_rd = 32'(gcfg_q);
            GW_SYNC:     glob_rd = 32'(sync_q);
            default:     glob_rd = '0;
        endcase
    end

    always_comb begin
        unique case (region)
            RG_GLOBAL: rd_next = glob_rd;
            RG_CHAN:   rd_next = chan_rd;
            RG_IDENT:  rd_next = 32'(ident_byte(id_idx));
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    assert_bad_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && region == RG_BADCH) |=> (bus_rdata == '0));

    assert_enable_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_wr && glob_word == GW_CONFIG) |=> (dma_on == $past(bus_wdata[0])));
endmodule

// File: tb/dmar_top_tb_top.sv
module dmar_top_tb_top;
    localparam int N8 = 8;
    localparam int N2 = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata8, rdata2;
    logic [N8-1:0] tc8 = '0, err8 = '0, chan_on8;
    logic [N2-1:0] chan_on2;
    logic        irq8, irq2, dma_on8, dma_on2;

    always #2 clk = ~clk;  // 250 MHz

    dmar_top #(.NCH(N8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata8),
        .tc_set(tc8), .err_set(err8), .irq(irq8), .dma_on(dma_on8),
        .chan_on(chan_on8)
    );

    dmar_top #(.NCH(N2)) dut2_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
        .tc_set(2'b00), .err_set(2'b00), .irq(irq2), .dma_on(dma_on2),
        .chan_on(chan_on2)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input int req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // read data is registered at the edge between the two negedges
    task automatic rd(input logic [11:0] a, output logic [31:0] v8,
                      output logic [31:0] v2);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v8 = rdata8; v2 = rdata2;
    endtask

    task automatic pulse(input logic [7:0] t, input logic [7:0] e);
        @(negedge clk);
        tc8 = t; err8 = e;
        @(negedge clk);
        tc8 = '0; err8 = '0;
    endtask

    typedef struct packed {
        logic        is_rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h100, 32'h11111111, 32'h0, 4'd2},        // R2 ch0 source
        '{1'b0, 12'h1E4, 32'hA5A5A5A5, 32'h0, 4'd2},        // R2 ch7 destination
        '{1'b0, 12'h128, 32'h00001238, 32'h0, 4'd2},        // R2 ch1 next pointer
        '{1'b0, 12'h16C, 32'h80000FFF, 32'h0, 4'd2},        // R2 ch3 control
        '{1'b0, 12'h114, 32'hFFFFFFFF, 32'h0, 4'd2},        // R2 reserved word 5
        '{1'b1, 12'h100, 32'h0, 32'h11111111, 4'd2},        // R2
        '{1'b1, 12'h1E4, 32'h0, 32'hA5A5A5A5, 4'd2},        // R2
        '{1'b1, 12'h128, 32'h0, 32'h00001238, 4'd2},        // R2
        '{1'b1, 12'h16C, 32'h0, 32'h80000FFF, 4'd2},        // R2
        '{1'b1, 12'h104, 32'h0, 32'h00000000, 4'd2},        // R2 untouched word
        '{1'b1, 12'h114, 32'h0, 32'h00000000, 4'd2},        // R2 reserved reads zero
        '{1'b0, 12'h030, 32'hFFFFFFF7, 32'h0, 4'd9},        // R9 config
        '{1'b1, 12'h030, 32'h0, 32'h00000007, 4'd9},        // R9
        '{1'b0, 12'h034, 32'hFFFFFFFF, 32'h0, 4'd9},        // R9 sync
        '{1'b1, 12'h034, 32'h0, 32'h0000FFFF, 4'd9},        // R9
        '{1'b0, 12'h020, 32'hFFFFFFFF, 32'h0, 4'd10},       // R10 request word
        '{1'b1, 12'h020, 32'h0, 32'h00000000, 4'd10},       // R10
        '{1'b1, 12'h02C, 32'h0, 32'h00000000, 4'd10},       // R10
        '{1'b1, 12'h0A0, 32'h0, 32'h00000000, 4'd10},       // R10 unmapped
        '{1'b1, 12'hFE0, 32'h0, 32'h00000080, 4'd8},        // R8
        '{1'b1, 12'hFE4, 32'h0, 32'h00000010, 4'd8},        // R8
        '{1'b1, 12'hFF0, 32'h0, 32'h0000000D, 4'd8},        // R8
        '{1'b1, 12'hFFC, 32'h0, 32'h000000B1, 4'd8}         // R8
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v8, v2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(1, {31'b0, irq8}, 32'h0, "irq after reset");
        chk(1, {24'b0, chan_on8}, 32'h0, "chan_on after reset");
        rst_n = 1'b1;
        rd(12'h100, v8, v2); chk(1, v8, 32'h0, "ch0 source after reset");
        rd(12'h030, v8, v2); chk(1, v8, 32'h0, "config after reset");
        rd(12'h014, v8, v2); chk(1, v8, 32'h0, "raw tc after reset");
        @(negedge clk);
        chk(11, rdata8, 32'h0, "rdata idle");  // R11

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                rd(VECS[i].addr, v8, v2);
                chk(int'(VECS[i].req), v8, VECS[i].exp, "vector read");
            end else begin
                wr(VECS[i].addr, VECS[i].data);
            end
        end
        chk(9, {31'b0, dma_on8}, 32'h1, "dma_on");  // R9

        // R7 enabled bitmap
        wr(12'h150, 32'h1);
        wr(12'h1B0, 32'h1);
        rd(12'h01C, v8, v2);
        chk(7, v8, 32'h24, "enabled word");
        chk(7, {24'b0, chan_on8}, 32'h24, "chan_on");

        // R5 R6 masks and combined interrupt
        wr(12'h150, 32'h8001);
        pulse(8'h0C, 8'h20);
        rd(12'h014, v8, v2); chk(4, v8, 32'h0C, "raw tc");
        rd(12'h018, v8, v2); chk(4, v8, 32'h20, "raw err");
        rd(12'h004, v8, v2); chk(5, v8, 32'h04, "masked tc");
        rd(12'h00C, v8, v2); chk(5, v8, 32'h00, "masked err");
        rd(12'h000, v8, v2); chk(5, v8, 32'h04, "combined");
        chk(6, {31'b0, irq8}, 32'h1, "irq tc");
        wr(12'h1B0, 32'h4001);
        rd(12'h000, v8, v2); chk(5, v8, 32'h24, "combined with err");
        wr(12'h008, 32'h04);
        rd(12'h014, v8, v2); chk(4, v8, 32'h08, "tc after clear");
        chk(6, {31'b0, irq8}, 32'h1, "irq err only");
        wr(12'h010, 32'h20);
        @(negedge clk);
        chk(6, {31'b0, irq8}, 32'h0, "irq all cleared");

        // R4 set beats clear in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h08; tc8 = 8'h08;
        @(negedge clk);
        bus_wr = 1'b0; tc8 = '0;
        rd(12'h014, v8, v2); chk(4, v8, 32'h08, "set wins over clear");
        wr(12'h008, 32'hFF);
        rd(12'h014, v8, v2); chk(4, v8, 32'h00, "clear all");

        // R3 R8 two-channel instance
        wr(12'h140, 32'hDEADBEEF);
        wr(12'h120, 32'h00C0FFEE);
        rd(12'h140, v8, v2); chk(3, v2, 32'h0, "bad channel read");
        rd(12'h120, v8, v2); chk(3, v2, 32'h00C0FFEE, "ch1 on small");
        rd(12'h01C, v8, v2); chk(3, v2, 32'h0, "bad channel enables ignored");
        rd(12'hFE0, v8, v2); chk(8, v2, 32'h81, "ident byte small");

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(1, {24'b0, chan_on8}, 32'h0, "chan_on after re-reset");
        chk(1, {31'b0, dma_on8}, 32'h0, "dma_on after re-reset");
        rd(12'h100, v8, v2); chk(1, v8, 32'h0, "ch0 after re-reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule